// File: doc/BRIEF.md
# Processor Operating-State Controller

This block is the sequencer that decides which operating state a small processor core occupies and drives the core's control strobes from that state. It holds one of six states: reset, program run, exception service, debug service, halt and sleep. It moves between them on one-cycle strobes from the instruction decoder (halt, sleep, return-from-exception, return-from-debug, breakpoint), on six exception request lines and on a debug request line.

On every entry into exception service, into debug service, or into program run out of reset, the controller issues a one-cycle vector-fetch request together with a 3-bit cause code. Two clock-gate enables are derived from the state. Halt stops only the core clock. Sleep also stops the peripheral/oscillator clock. Both low-power states can be left only through NMI, an external interrupt or reset. The datapath, register saving and the vector table are outside the block.

The state code on `state_o` is: 0 reset, 1 run, 2 exception service, 3 debug service, 4 halt, 5 sleep. Reset is synchronous and active low.

Top module: `core_state_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state is reset (0), `vec_req` is 0, `vec_cause` is 0, and both clock enables are 1.
- R2: At the first edge with `rst_n` high, the state becomes run (1) and `vec_req` is 1 with cause 0 for exactly one cycle.
- R3: In run, `halt_ins` moves to halt (4), where `core_clk_en`=0 and `periph_clk_en`=1. `sleep_ins` moves to sleep (5), where both enables are 0.
- R4: In run, an exception request moves to exception service (2) with `vec_req`=1 and cause NMI=2, undefined instruction=3, misaligned address=4, divide by zero=5, software trap=6, external interrupt=7.
- R5: Among simultaneous requests the lowest cause code wins, and any exception takes precedence over a halt or sleep strobe. Halt takes precedence over sleep.
- R6: `brk_ins` or `dbg_req` in run or exception service moves to debug service (3) with `vec_req`=1 and cause 1, ahead of every exception request.
- R7: `reti_ins` in exception service, and `retd_ins` in debug service, return to run (1) without a vector-fetch request.
- R8: In halt or sleep, only `nmi` (cause 2, takes precedence) or `irq_ext` (cause 7) leaves, going to exception service. Both enables are 1 in the cycle the state changes. All other inputs are ignored.
- R9: A return strobe in the wrong state is ignored: `reti_ins` in debug service or run, and `retd_ins` outside debug service.
- R10: In debug service every request except `retd_ins` is ignored. In exception service all exception requests and halt/sleep strobes are ignored.
- R11: A `vec_req` pulse occurs only in the cycle after a state change. Reset from any state, including halt, returns to reset with both enables high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_ins | input | 1 | Halt instruction strobe |
| sleep_ins | input | 1 | Sleep instruction strobe |
| reti_ins | input | 1 | Return-from-exception strobe |
| retd_ins | input | 1 | Return-from-debug strobe |
| brk_ins | input | 1 | Breakpoint instruction strobe |
| irq_ext | input | 1 | External interrupt request |
| exc_swtrap | input | 1 | Software trap request |
| exc_misalign | input | 1 | Misaligned address fault |
| exc_div0 | input | 1 | Divide-by-zero fault |
| nmi | input | 1 | Non-maskable interrupt |
| exc_undef | input | 1 | Undefined or extension instruction fault |
| dbg_req | input | 1 | Debug exception request |
| state_o | output | 3 | Current state code |
| vec_req | output | 1 | One-cycle vector-fetch request |
| vec_cause | output | 3 | Cause code of the vector fetch |
| core_clk_en | output | 1 | Core clock-gate enable |
| periph_clk_en | output | 1 | Peripheral/oscillator clock-gate enable |

## Verification
The hardest situations to reach from the ports are those where an input arrives while the controller sits in a state other than run. Examples are a stray return strobe in debug service, or a burst of faults during halt or sleep. Each table vector therefore carries a preparatory stimulus that first drives the controller into the wanted state, behind a fresh reset. The vector's own stimulus then follows in the next cycle, often several requests at once so that priority and masking are both exercised.

// File: rtl/csc_pkg.sv
// Shared types and cause codes for the operating-state controller.
// Assumes: the cause code order is also the arbitration priority (lowest wins).
package csc_pkg;
    localparam int STATE_W = 3;
    localparam int CAUSE_N = 8;
    localparam int CAUSE_W = $clog2(CAUSE_N);

    typedef enum logic [STATE_W-1:0] {
        ST_RESET = 3'd0,
        ST_RUN   = 3'd1,
        ST_EXC   = 3'd2,
        ST_DBG   = 3'd3,
        ST_HALT  = 3'd4,
        ST_SLEEP = 3'd5
    } op_state_t;

    localparam logic [CAUSE_W-1:0] C_RESET   = 3'd0;
    localparam logic [CAUSE_W-1:0] C_DEBUG   = 3'd1;
    localparam logic [CAUSE_W-1:0] C_NMI     = 3'd2;
    localparam logic [CAUSE_W-1:0] C_UNDEF   = 3'd3;
    localparam logic [CAUSE_W-1:0] C_MISALGN = 3'd4;
    localparam logic [CAUSE_W-1:0] C_DIV0    = 3'd5;
    localparam logic [CAUSE_W-1:0] C_SWTRAP  = 3'd6;
    localparam logic [CAUSE_W-1:0] C_EXTIRQ  = 3'd7;
endpackage

// File: rtl/csc_prio_enc.sv
// Fixed-priority encoder: reports whether any request is set and the index
// of the lowest set bit. Assumes N >= 2.
module csc_prio_enc #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic         hit,
    output logic [W-1:0] idx
);
    // Scan from the top so the lowest set index is assigned last and wins.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = W'(i);
            end
        end
    end
endmodule

// File: rtl/csc_next_state.sv
// Combinational transition logic. It masks the request vector by the current
// state, arbitrates the survivors and chooses the next state and vector fetch.
// Assumes: the request bit index equals the cause code.
module csc_next_state
    import csc_pkg::*;
(
    input  op_state_t          cur,
    input  logic [CAUSE_N-1:0] req_raw,
    input  logic               halt_ins,
    input  logic               sleep_ins,
    input  logic               reti_ins,
    input  logic               retd_ins,
    output op_state_t          nxt,
    output logic               vec_set,
    output logic [CAUSE_W-1:0] vec_code
);
    logic [CAUSE_N-1:0] mask;
    logic               hit;
    logic [CAUSE_W-1:0] idx;

    // Select which request sources each state listens to.
    always_comb begin
        mask = '0;
        case (cur)
            ST_RUN:   mask = '1;
            ST_EXC:   mask[C_DEBUG] = 1'b1;
            ST_HALT,
            ST_SLEEP: begin
                mask[C_NMI]    = 1'b1;
                mask[C_EXTIRQ] = 1'b1;
            end
            default:  mask = '0;
        endcase
    end

    csc_prio_enc #(.N(CAUSE_N)) u_arb (
        .req (req_raw & mask),
        .hit (hit),
        .idx (idx)
    );

    // Pick the next state. A request that survives the mask beats any strobe.
    always_comb begin
        nxt      = cur;
        vec_set  = 1'b0;
        vec_code = idx;
        if (cur == ST_RESET) begin
            nxt      = ST_RUN;
            vec_set  = 1'b1;
            vec_code = C_RESET;
        end else if (hit) begin
            nxt     = (idx == C_DEBUG) ? ST_DBG : ST_EXC;
            vec_set = 1'b1;
        end else begin
            case (cur)
                ST_RUN: begin
                    if (halt_ins)       nxt = ST_HALT;
                    else if (sleep_ins) nxt = ST_SLEEP;
                end
                ST_EXC:  if (reti_ins) nxt = ST_RUN;
                ST_DBG:  if (retd_ins) nxt = ST_RUN;
                default: nxt = cur;
            endcase
        end
    end
endmodule

// File: rtl/csc_clk_en_dec.sv
// Decodes the clock-gate enables from the registered state.
// Assumes: the enables follow the state register directly, so they return in
// the same cycle the state leaves halt or sleep.
module csc_clk_en_dec
    import csc_pkg::*;
(
    input  op_state_t state,
    output logic      core_en,
    output logic      periph_en
);
    // Halt stops the core clock only; sleep stops both clocks.
    always_comb begin
        core_en   = !(state == ST_HALT || state == ST_SLEEP);
        periph_en = (state != ST_SLEEP);
    end
endmodule

// File: rtl/core_state_ctrl.sv
// Operating-state controller for a small processor core. It holds the state,
// registers the vector-fetch pulse and cause, and drives the clock enables.
// Assumes: decoder strobes and request lines are synchronous to clk, and
// rst_n is synchronous and active low.
module core_state_ctrl
    import csc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               halt_ins,
    input  logic               sleep_ins,
    input  logic               reti_ins,
    input  logic               retd_ins,
    input  logic               brk_ins,
    input  logic               irq_ext,
    input  logic               exc_swtrap,
    input  logic               exc_misalign,
    input  logic               exc_div0,
    input  logic               nmi,
    input  logic               exc_undef,
    input  logic               dbg_req,
    output logic [STATE_W-1:0] state_o,
    output logic               vec_req,
    output logic [CAUSE_W-1:0] vec_cause,
    output logic               core_clk_en,
    output logic               periph_clk_en
);
    op_state_t          state_q, state_d;
    logic               vec_set;
    logic [CAUSE_W-1:0] vec_code;
    logic [CAUSE_N-1:0] req_raw;

    // Place each request at the bit index equal to its cause code.
    always_comb begin
        req_raw            = '0;
        req_raw[C_DEBUG]   = brk_ins | dbg_req;
        req_raw[C_NMI]     = nmi;
        req_raw[C_UNDEF]   = exc_undef;
        req_raw[C_MISALGN] = exc_misalign;
        req_raw[C_DIV0]    = exc_div0;
        req_raw[C_SWTRAP]  = exc_swtrap;
        req_raw[C_EXTIRQ]  = irq_ext;
    end

    csc_next_state u_ns (
        .cur       (state_q),
        .req_raw   (req_raw),
        .halt_ins  (halt_ins),
        .sleep_ins (sleep_ins),
        .reti_ins  (reti_ins),
        .retd_ins  (retd_ins),
        .nxt       (state_d),
        .vec_set   (vec_set),
        .vec_code  (vec_code)
    );

    // State, vector pulse and cause registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_RESET;
            vec_req   <= 1'b0;
            vec_cause <= C_RESET;
        end else begin
            state_q <= state_d;
            vec_req <= vec_set;
            if (vec_set) vec_cause <= vec_code;
        end
    end

    csc_clk_en_dec u_ce (
        .state     (state_q),
        .core_en   (core_clk_en),
        .periph_en (periph_clk_en)
    );

    assign state_o = state_q;
endmodule

// File: rtl/csc_chk.sv
// Property checker for core_state_ctrl, attached with bind.
module csc_chk
    import csc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               reti_ins,
    input logic               retd_ins,
    input logic               brk_ins,
    input logic               dbg_req,
    input logic               nmi,
    input logic               irq_ext,
    input logic [STATE_W-1:0] state_o,
    input logic               vec_req,
    input logic [CAUSE_W-1:0] vec_cause,
    input logic               core_clk_en,
    input logic               periph_clk_en
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (state_o == ST_RESET) && !vec_req && core_clk_en && periph_clk_en);

    // R3
    halt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_HALT) |-> !core_clk_en && periph_clk_en);

    // R3
    sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_SLEEP) |-> !core_clk_en && !periph_clk_en);

    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_HALT && !nmi && !irq_ext) |=> (state_o == ST_HALT));

    // R8
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_SLEEP && !nmi && !irq_ext) |=> (state_o == ST_SLEEP));

    // R10
    dbg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_DBG && !retd_ins) |=> (state_o == ST_DBG));

    // R7
    reti_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_EXC && reti_ins && !brk_ins && !dbg_req)
        |=> (state_o == ST_RUN) && !vec_req);

    // R6
    dbg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && state_o == ST_DBG) |-> (vec_cause == C_DEBUG));

    // R11
    vec_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> (state_o != $past(state_o)));
endmodule

bind core_state_ctrl csc_chk u_chk (.*);

// File: tb/tb_core_state_ctrl.sv
module tb_core_state_ctrl;
    logic clk = 1'b0;
    always #4 clk = ~clk;  // 125 MHz

    logic rst_n, halt_ins, sleep_ins, reti_ins, retd_ins, brk_ins, irq_ext;
    logic exc_swtrap, exc_misalign, exc_div0, nmi, exc_undef, dbg_req;
    logic [2:0] state_o, vec_cause;
    logic vec_req, core_clk_en, periph_clk_en;

    core_state_ctrl dut (.*);

    // Stimulus bit positions, local to the bench.
    localparam logic [11:0] I_HALT = 12'h001, I_SLEEP = 12'h002, I_RETI = 12'h004,
                            I_RETD = 12'h008, I_BRK   = 12'h010, I_IRQ  = 12'h020,
                            I_SWT  = 12'h040, I_MIS   = 12'h080, I_DIV  = 12'h100,
                            I_NMI  = 12'h200, I_UND   = 12'h400, I_DBG  = 12'h800;
    localparam logic [2:0] S_RST = 3'd0, S_RUN = 3'd1, S_EXC = 3'd2,
                           S_DBG = 3'd3, S_HLT = 3'd4, S_SLP = 3'd5;
    localparam logic [11:0] NOISE = I_SWT | I_MIS | I_DIV | I_UND | I_DBG | I_BRK | I_RETI;

    typedef struct packed {
        logic [11:0] pre;
        logic [11:0] stim;
        logic [2:0]  st;
        logic        vec;
        logic [2:0]  cause;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t TBL [NV] = '{
        '{12'h0,   I_HALT,                    S_HLT, 1'b0, 3'd0, 4'd3},  // R3
        '{12'h0,   I_SLEEP,                   S_SLP, 1'b0, 3'd0, 4'd3},  // R3
        '{12'h0,   I_IRQ,                     S_EXC, 1'b1, 3'd7, 4'd4},  // R4
        '{12'h0,   I_SWT,                     S_EXC, 1'b1, 3'd6, 4'd4},  // R4
        '{12'h0,   I_MIS,                     S_EXC, 1'b1, 3'd4, 4'd4},  // R4
        '{12'h0,   I_DIV,                     S_EXC, 1'b1, 3'd5, 4'd4},  // R4
        '{12'h0,   I_NMI,                     S_EXC, 1'b1, 3'd2, 4'd4},  // R4
        '{12'h0,   I_UND,                     S_EXC, 1'b1, 3'd3, 4'd4},  // R4
        '{12'h0,   I_IRQ|I_SWT|I_HALT,        S_EXC, 1'b1, 3'd6, 4'd5},  // R5
        '{12'h0,   I_NMI|I_UND|I_MIS,         S_EXC, 1'b1, 3'd2, 4'd5},  // R5
        '{12'h0,   I_HALT|I_SLEEP,            S_HLT, 1'b0, 3'd0, 4'd5},  // R5
        '{12'h0,   I_BRK,                     S_DBG, 1'b1, 3'd1, 4'd6},  // R6
        '{12'h0,   I_DBG|I_NMI|I_UND,         S_DBG, 1'b1, 3'd1, 4'd6},  // R6
        '{I_IRQ,   I_DBG,                     S_DBG, 1'b1, 3'd1, 4'd6},  // R6
        '{I_NMI,   I_RETI,                    S_RUN, 1'b0, 3'd0, 4'd7},  // R7
        '{I_BRK,   I_RETD,                    S_RUN, 1'b0, 3'd0, 4'd7},  // R7
        '{I_HALT,  I_IRQ,                     S_EXC, 1'b1, 3'd7, 4'd8},  // R8
        '{I_SLEEP, I_NMI|I_IRQ,               S_EXC, 1'b1, 3'd2, 4'd8},  // R8
        '{I_HALT,  NOISE,                     S_HLT, 1'b0, 3'd0, 4'd8},  // R8
        '{I_SLEEP, NOISE,                     S_SLP, 1'b0, 3'd0, 4'd8},  // R8
        '{I_BRK,   I_RETI,                    S_DBG, 1'b0, 3'd0, 4'd9},  // R9
        '{12'h0,   I_RETD|I_RETI,             S_RUN, 1'b0, 3'd0, 4'd9},  // R9
        '{I_IRQ,   I_RETD,                    S_EXC, 1'b0, 3'd0, 4'd9},  // R9
        '{I_BRK,   I_NMI|I_IRQ|I_UND|I_HALT|I_SLEEP, S_DBG, 1'b0, 3'd0, 4'd10}, // R10
        '{I_SWT,   I_NMI|I_IRQ|I_HALT|I_SLEEP, S_EXC, 1'b0, 3'd0, 4'd10}  // R10
    };

    int checks = 0;
    int errors = 0;

    task automatic drive(input logic [11:0] v);
        {dbg_req, exc_undef, nmi, exc_div0, exc_misalign, exc_swtrap,
         irq_ext, brk_ins, retd_ins, reti_ins, sleep_ins, halt_ins} = v;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One stimulus cycle: drive after a falling edge, clear at the next one.
    task automatic step(input logic [11:0] v);
        @(negedge clk); drive(v);
        @(negedge clk); drive(12'h0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; drive(12'h0);
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic chk_en(input string tag, input logic [2:0] st);
        chk(tag, {7'd0, core_clk_en}, {7'd0, !(st == S_HLT || st == S_SLP)});
        chk(tag, {7'd0, periph_clk_en}, {7'd0, st != S_SLP});
    endtask

    initial begin
        rst_n = 1'b0;
        drive(12'h0);
        // R1: values held during reset, with noise on the inputs.
        @(negedge clk); drive(I_NMI | I_HALT | I_DBG);
        @(negedge clk); @(negedge clk);
        chk("R1 state", {5'd0, state_o}, {5'd0, S_RST});
        chk("R1 vec_req", {7'd0, vec_req}, 8'd0);
        chk("R1 cause", {5'd0, vec_cause}, 8'd0);
        chk_en("R1 enables", S_RST);
        drive(12'h0);
        // R2: release gives run plus a single reset-vector fetch.
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 state", {5'd0, state_o}, {5'd0, S_RUN});
        chk("R2 vec_req", {7'd0, vec_req}, 8'd1);
        chk("R2 cause", {5'd0, vec_cause}, 8'd0);
        @(negedge clk);
        chk("R2 pulse width", {7'd0, vec_req}, 8'd0);

        // Table walk.
        for (int k = 0; k < NV; k++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", TBL[k].req, k);
            do_reset();
            if (TBL[k].pre != 12'h0) step(TBL[k].pre);
            step(TBL[k].stim);
            chk({tag, " state"}, {5'd0, state_o}, {5'd0, TBL[k].st});
            chk({tag, " vec_req"}, {7'd0, vec_req}, {7'd0, TBL[k].vec});
            if (TBL[k].vec) chk({tag, " cause"}, {5'd0, vec_cause}, {5'd0, TBL[k].cause});
            chk_en(tag, TBL[k].st);
        end

        // R11: the vector pulse ends after one cycle even on a two-step chain.
        do_reset();
        step(I_NMI);
        chk("R11 pulse set", {7'd0, vec_req}, 8'd1);
        @(negedge clk);
        chk("R11 pulse clear", {7'd0, vec_req}, 8'd0);
        // R11: reset out of sleep returns to reset with both enables high.
        do_reset();
        step(I_SLEEP);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R11 reset from sleep", {5'd0, state_o}, {5'd0, S_RST});
        chk_en("R11 enables", S_RST);
        rst_n = 1'b1;
        // R8: enables come back in the very cycle halt is left.
        do_reset();
        step(I_HALT);
        chk("R8 core gated", {7'd0, core_clk_en}, 8'd0);
        step(I_IRQ);
        chk("R8 core restored", {7'd0, core_clk_en}, 8'd1);
        // R9: reti in run is ignored.
        do_reset();
        step(I_RETI);
        chk("R9 reti in run", {5'd0, state_o}, {5'd0, S_RUN});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule